// File: doc/BRIEF.md
# Transmit Mailbox Arbitration Engine

This block holds a small array of CAN transmit mailboxes that the CPU fills through a simple write port. A mailbox joins arbitration only once its control word is written with the pending transmit code, which is the last step of preparing it. The engine runs arbitration only at two bus moments, a bus-free strobe or an inter-frame-gap strobe, and only while it is idle and at least one mailbox is pending. It then picks one winner and copies that winner's identifier, length and payload into a single staging buffer. The bit-level transmitter reads the frame from that buffer.

While the frame is on the bus, an identifier-start strobe latches the free-running timer. A success strobe from the transmitter starts a write-back step. That step stores the latched timer as the mailbox timestamp, returns the mailbox code to the idle code and raises the mailbox's interrupt flag. A loss or abort strobe leaves the mailbox pending, so it competes again at the next bus moment. The staging buffer never reports more than eight payload bytes, whatever the length code says.

The controller is a four-state machine. IDLE goes to MOVE on the transition "go" (a strobe with a pending mailbox). MOVE goes to BUSY on "load" (staging buffer filled). BUSY goes to WB on "ok" (success) or back to IDLE on "lost" (abort). WB goes to IDLE on "done" (write-back made).

Top module: `txmb_arbiter`

## Requirements
- R1: Arbitration starts only in IDLE, on a cycle where `bus_free` or `ifs_gap` is high and at least one mailbox is pending. `smb_valid` rises two cycles after that strobe is sampled. Strobes in any other state, or with no mailbox pending, have no effect.
- R2: The winner is the pending mailbox with the numerically lowest identifier. When identifiers are equal, the lowest mailbox index wins. `smb_mb` gives the winner's index.
- R3: While `smb_valid` is high, `smb_id`, `smb_len` and `smb_data` hold the identifier, length code and 64-bit payload the winner had when the frame was moved out. They stay stable until the send ends.
- R4: `smb_nbytes` equals the length code when it is at most 8, and 8 otherwise.
- R5: While sending, an `id_field_start` pulse latches `timer_now`. That value becomes the mailbox timestamp on success. The latch is cleared to 0 at move-out.
- R6: Two cycles after `tx_done_ok` is sampled in BUSY, the winner's code reads 4'h8 and its `irq_flags` bit is 1.
- R7: After `tx_lost` in BUSY, the engine returns to IDLE and the mailbox code stays 4'hC. The mailbox takes part in the next arbitration.
- R8: Only code 4'hC counts as pending. Writes use `cpu_wr_sel`: 0 selects the control word (code in bits [11:8], length in bits [3:0]), 1 selects the identifier (bits [10:0]), 2 selects payload bits [31:0] and 3 selects payload bits [63:32]. `cpu_rd_code` and `cpu_rd_stamp` show the mailbox selected by `cpu_rd_idx`. The write-back overrides a CPU write to the same mailbox in the same cycle.
- R9: Writing 1 to a bit of `cpu_flag_clr` clears that interrupt flag on the next cycle. A flag being set in the same cycle wins over the clear.
- R10: After reset, all codes, lengths, identifiers, payloads and timestamps are 0, every flag is 0 and `smb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_idx | input | IDX_W | Mailbox index written |
| cpu_wr_sel | input | 2 | Field select (see R8) |
| cpu_wr_data | input | 32 | Write data |
| cpu_flag_clr | input | NUM_MB | Write-1-to-clear for the interrupt flags |
| cpu_rd_idx | input | IDX_W | Mailbox index read |
| cpu_rd_code | output | 4 | Code of the mailbox that is read |
| cpu_rd_stamp | output | TS_W | Timestamp of the mailbox that is read |
| bus_free | input | 1 | Bus sensed free strobe |
| ifs_gap | input | 1 | Inter-frame-gap strobe |
| id_field_start | input | 1 | Start of identifier field on the bus |
| tx_done_ok | input | 1 | Transmitter reports success |
| tx_lost | input | 1 | Transmitter reports loss or abort |
| timer_now | input | TS_W | Free-running timer |
| smb_valid | output | 1 | Staging buffer holds a frame being sent |
| smb_mb | output | IDX_W | Winner mailbox index |
| smb_id | output | ID_W | Staged identifier |
| smb_len | output | 4 | Staged length code |
| smb_nbytes | output | 4 | Payload bytes to send |
| smb_data | output | 64 | Staged payload |
| irq_flags | output | NUM_MB | Per-mailbox interrupt flags |

## Verification
A strobe sampled at one edge moves the engine to MOVE. The frame shows up in the staging outputs after the following edge, so `smb_valid` is due two cycles after the strobe. A success strobe reaches the mailbox code, timestamp and flag two edges later, through WB. A flag clear shows after one edge, and the read port is combinational. The bench updates its reference model at each rising edge from the inputs it drove after the previous one, and compares every output at the falling edge. Each result is therefore checked in exactly the cycle it becomes due, and inputs change 2 ns after the rising edge, well away from the sampling point.

// File: rtl/txmb_pkg.sv
`timescale 1ns/1ps
package txmb_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MOVE = 2'd1,
        S_BUSY = 2'd2,
        S_WB   = 2'd3
    } arb_state_t;

    localparam logic [3:0] CODE_TX_IDLE = 4'h8;
    localparam logic [3:0] CODE_TX_SEND = 4'hC;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_ID   = 2'd1;
    localparam logic [1:0] SEL_DLO  = 2'd2;
    localparam logic [1:0] SEL_DHI  = 2'd3;

    localparam int MAX_BYTES = 8;
endpackage

// File: rtl/txmb_store.sv
`timescale 1ns/1ps
module txmb_store
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 4,
    parameter int ID_W   = 11,
    parameter int TS_W   = 16,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [1:0]                   wr_sel,
    input  logic [31:0]                  wr_data,
    input  logic [NUM_MB-1:0]            flag_clr,
    input  logic                         wb_en,
    input  logic [IDX_W-1:0]             wb_idx,
    input  logic [TS_W-1:0]              wb_stamp,
    input  logic [IDX_W-1:0]             sel_idx,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [NUM_MB-1:0]            pend_vec,
    output logic [NUM_MB-1:0][ID_W-1:0]  id_vec,
    output logic [ID_W-1:0]              sel_id,
    output logic [3:0]                   sel_len,
    output logic [63:0]                  sel_data,
    output logic [3:0]                   rd_code,
    output logic [TS_W-1:0]              rd_stamp,
    output logic [NUM_MB-1:0]            flags
);
    logic [3:0]      code_q  [NUM_MB];
    logic [3:0]      len_q   [NUM_MB];
    logic [ID_W-1:0] ident_q [NUM_MB];
    logic [63:0]     data_q  [NUM_MB];
    logic [TS_W-1:0] stamp_q [NUM_MB];
    logic [NUM_MB-1:0] set_vec;

    for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
        logic hit_cpu;
        logic hit_wb;
        assign hit_cpu = wr_en && (wr_idx == IDX_W'(m));
        assign hit_wb  = wb_en && (wb_idx == IDX_W'(m));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q[m]  <= '0;
                len_q[m]   <= '0;
                ident_q[m] <= '0;
                data_q[m]  <= '0;
                stamp_q[m] <= '0;
            end else begin
                if (hit_cpu) begin
                    unique case (wr_sel)
                        SEL_CTRL: begin
                            code_q[m] <= wr_data[11:8];
                            len_q[m]  <= wr_data[3:0];
                        end
                        SEL_ID:  ident_q[m]       <= wr_data[ID_W-1:0];
                        SEL_DLO: data_q[m][31:0]  <= wr_data;
                        SEL_DHI: data_q[m][63:32] <= wr_data;
                        default: ;
                    endcase
                end
                if (hit_wb) begin
                    code_q[m]  <= CODE_TX_IDLE;
                    stamp_q[m] <= wb_stamp;
                end
            end
        end

        assign pend_vec[m] = (code_q[m] == CODE_TX_SEND);
        assign id_vec[m]   = ident_q[m];
        assign set_vec[m]  = hit_wb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | set_vec;
    end

    assign sel_id   = ident_q[sel_idx];
    assign sel_len  = len_q[sel_idx];
    assign sel_data = data_q[sel_idx];
    assign rd_code  = code_q[rd_idx];
    assign rd_stamp = stamp_q[rd_idx];

    AST_WB_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> flags[$past(wb_idx)]); // R6
    AST_WB_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> (code_q[$past(wb_idx)] == CODE_TX_IDLE)); // R6
endmodule

// File: rtl/txmb_pick.sv
`timescale 1ns/1ps
module txmb_pick #(
    parameter int NUM_MB = 4,
    parameter int ID_W   = 11,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic [NUM_MB-1:0]            pend_vec,
    input  logic [NUM_MB-1:0][ID_W-1:0]  id_vec,
    output logic                         any_pend,
    output logic [IDX_W-1:0]             win_idx
);
    logic [ID_W-1:0] best_id;

    always_comb begin
        any_pend = 1'b0;
        win_idx  = '0;
        best_id  = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pend_vec[i] && (!any_pend || (id_vec[i] < best_id))) begin
                any_pend = 1'b1;
                win_idx  = IDX_W'(i);
                best_id  = id_vec[i];
            end
        end
    end
endmodule

// File: rtl/txmb_ctrl.sv
`timescale 1ns/1ps
module txmb_ctrl
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 4,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_free,
    input  logic             ifs_gap,
    input  logic             tx_ok,
    input  logic             tx_lost,
    input  logic             any_pend,
    input  logic [IDX_W-1:0] pick_idx,
    output logic             load,
    output logic             sending,
    output logic             wb_en,
    output logic [IDX_W-1:0] win_idx
);
    arb_state_t state, state_nx;
    logic go;

    assign go = (bus_free || ifs_gap) && any_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            win_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && go) win_idx <= pick_idx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (go) state_nx = S_MOVE;
            S_MOVE: state_nx = S_BUSY;
            S_BUSY: begin
                if (tx_ok)        state_nx = S_WB;
                else if (tx_lost) state_nx = S_IDLE;
            end
            S_WB:   state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        sending = 1'b0;
        wb_en   = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_MOVE: load    = 1'b1;
            S_BUSY: sending = 1'b1;
            S_WB:   wb_en   = 1'b1;
            default: ;
        endcase
    end

    AST_GO_STARTS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && (bus_free || ifs_gap) && any_pend) |=> (state == S_MOVE)); // R1
    AST_NO_PEND_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !any_pend) |=> (state == S_IDLE)); // R1
    AST_OK_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && tx_ok) |=> (state == S_WB)); // R6
    AST_LOST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && !tx_ok && tx_lost) |=> (state == S_IDLE)); // R7
endmodule

// File: rtl/txmb_stage.sv
`timescale 1ns/1ps
module txmb_stage
    import txmb_pkg::*;
#(
    parameter int NUM_MB = 4,
    parameter int ID_W   = 11,
    parameter int TS_W   = 16,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             sending,
    input  logic             id_start,
    input  logic [TS_W-1:0]  timer,
    input  logic [IDX_W-1:0] in_mb,
    input  logic [ID_W-1:0]  in_id,
    input  logic [3:0]       in_len,
    input  logic [63:0]      in_data,
    output logic [IDX_W-1:0] smb_mb,
    output logic [ID_W-1:0]  smb_id,
    output logic [3:0]       smb_len,
    output logic [3:0]       smb_nbytes,
    output logic [63:0]      smb_data,
    output logic [TS_W-1:0]  cap_stamp
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smb_mb     <= '0;
            smb_id     <= '0;
            smb_len    <= '0;
            smb_nbytes <= '0;
            smb_data   <= '0;
            cap_stamp  <= '0;
        end else if (load) begin
            smb_mb     <= in_mb;
            smb_id     <= in_id;
            smb_len    <= in_len;
            smb_nbytes <= (in_len > 4'(MAX_BYTES)) ? 4'(MAX_BYTES) : in_len;
            smb_data   <= in_data;
            cap_stamp  <= '0;
        end else if (sending && id_start) begin
            cap_stamp  <= timer;
        end
    end

    AST_STAGE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && $past(sending)) |-> ($stable(smb_id) && $stable(smb_data))); // R3
endmodule

// File: rtl/txmb_arbiter.sv
`timescale 1ns/1ps
module txmb_arbiter #(
    parameter int NUM_MB = 4,
    parameter int ID_W   = 11,
    parameter int TS_W   = 16,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [IDX_W-1:0]  cpu_wr_idx,
    input  logic [1:0]        cpu_wr_sel,
    input  logic [31:0]       cpu_wr_data,
    input  logic [NUM_MB-1:0] cpu_flag_clr,
    input  logic [IDX_W-1:0]  cpu_rd_idx,
    output logic [3:0]        cpu_rd_code,
    output logic [TS_W-1:0]   cpu_rd_stamp,
    input  logic              bus_free,
    input  logic              ifs_gap,
    input  logic              id_field_start,
    input  logic              tx_done_ok,
    input  logic              tx_lost,
    input  logic [TS_W-1:0]   timer_now,
    output logic              smb_valid,
    output logic [IDX_W-1:0]  smb_mb,
    output logic [ID_W-1:0]   smb_id,
    output logic [3:0]        smb_len,
    output logic [3:0]        smb_nbytes,
    output logic [63:0]       smb_data,
    output logic [NUM_MB-1:0] irq_flags
);
    logic [NUM_MB-1:0]           pend_vec;
    logic [NUM_MB-1:0][ID_W-1:0] id_vec;
    logic                        any_pend;
    logic [IDX_W-1:0]            pick_idx;
    logic [IDX_W-1:0]            win_idx;
    logic                        load, sending, wb_en;
    logic [ID_W-1:0]             sel_id;
    logic [3:0]                  sel_len;
    logic [63:0]                 sel_data;
    logic [TS_W-1:0]             cap_stamp;

    txmb_store #(.NUM_MB(NUM_MB), .ID_W(ID_W), .TS_W(TS_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr_en),
        .wr_idx   (cpu_wr_idx),
        .wr_sel   (cpu_wr_sel),
        .wr_data  (cpu_wr_data),
        .flag_clr (cpu_flag_clr),
        .wb_en    (wb_en),
        .wb_idx   (win_idx),
        .wb_stamp (cap_stamp),
        .sel_idx  (win_idx),
        .rd_idx   (cpu_rd_idx),
        .pend_vec (pend_vec),
        .id_vec   (id_vec),
        .sel_id   (sel_id),
        .sel_len  (sel_len),
        .sel_data (sel_data),
        .rd_code  (cpu_rd_code),
        .rd_stamp (cpu_rd_stamp),
        .flags    (irq_flags)
    );

    txmb_pick #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_pick (
        .pend_vec (pend_vec),
        .id_vec   (id_vec),
        .any_pend (any_pend),
        .win_idx  (pick_idx)
    );

    txmb_ctrl #(.NUM_MB(NUM_MB)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_free (bus_free),
        .ifs_gap  (ifs_gap),
        .tx_ok    (tx_done_ok),
        .tx_lost  (tx_lost),
        .any_pend (any_pend),
        .pick_idx (pick_idx),
        .load     (load),
        .sending  (sending),
        .wb_en    (wb_en),
        .win_idx  (win_idx)
    );

    txmb_stage #(.NUM_MB(NUM_MB), .ID_W(ID_W), .TS_W(TS_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .sending    (sending),
        .id_start   (id_field_start),
        .timer      (timer_now),
        .in_mb      (win_idx),
        .in_id      (sel_id),
        .in_len     (sel_len),
        .in_data    (sel_data),
        .smb_mb     (smb_mb),
        .smb_id     (smb_id),
        .smb_len    (smb_len),
        .smb_nbytes (smb_nbytes),
        .smb_data   (smb_data),
        .cap_stamp  (cap_stamp)
    );

    assign smb_valid = sending;

    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> pend_vec[win_idx]); // R2
endmodule

// File: tb/txmb_arbiter_test.sv
`timescale 1ns/1ps
module txmb_arbiter_test;
    localparam int NMB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_wr_en = 1'b0;
    logic [1:0] cpu_wr_idx = '0;
    logic [1:0] cpu_wr_sel = '0;
    logic [31:0] cpu_wr_data = '0;
    logic [3:0] cpu_flag_clr = '0;
    logic [1:0] cpu_rd_idx = '0;
    logic [3:0] cpu_rd_code;
    logic [15:0] cpu_rd_stamp;
    logic bus_free = 1'b0, ifs_gap = 1'b0, id_field_start = 1'b0;
    logic tx_done_ok = 1'b0, tx_lost = 1'b0;
    logic [15:0] timer_now = 16'h0100;
    logic smb_valid;
    logic [1:0] smb_mb;
    logic [10:0] smb_id;
    logic [3:0] smb_len, smb_nbytes;
    logic [63:0] smb_data;
    logic [3:0] irq_flags;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    txmb_arbiter uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_idx(cpu_wr_idx), .cpu_wr_sel(cpu_wr_sel),
        .cpu_wr_data(cpu_wr_data), .cpu_flag_clr(cpu_flag_clr),
        .cpu_rd_idx(cpu_rd_idx), .cpu_rd_code(cpu_rd_code), .cpu_rd_stamp(cpu_rd_stamp),
        .bus_free(bus_free), .ifs_gap(ifs_gap), .id_field_start(id_field_start),
        .tx_done_ok(tx_done_ok), .tx_lost(tx_lost), .timer_now(timer_now),
        .smb_valid(smb_valid), .smb_mb(smb_mb), .smb_id(smb_id), .smb_len(smb_len),
        .smb_nbytes(smb_nbytes), .smb_data(smb_data), .irq_flags(irq_flags)
    );

    // Behavioural reference model
    logic [3:0]  m_code [NMB];
    logic [3:0]  m_len  [NMB];
    logic [10:0] m_id   [NMB];
    logic [63:0] m_dat  [NMB];
    logic [15:0] m_ts   [NMB];
    logic [3:0]  m_flag;
    int          m_phase;
    int          m_win;
    int          m_best;
    int          m_next;
    logic [3:0]  m_set;
    logic [15:0] m_cap;
    int          s_mb;
    logic [10:0] s_id;
    logic [3:0]  s_len;
    logic [63:0] s_dat;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NMB; i++) begin
                m_code[i] = '0; m_len[i] = '0; m_id[i] = '0; m_dat[i] = '0; m_ts[i] = '0;
            end
            m_flag = '0; m_phase = 0; m_win = 0; m_cap = '0;
            s_mb = 0; s_id = '0; s_len = '0; s_dat = '0;
        end else begin
            m_next = m_phase;
            m_set  = '0;
            case (m_phase)
                0: if (bus_free || ifs_gap) begin
                    m_best = -1;
                    for (int i = 0; i < NMB; i++)
                        if (m_code[i] == 4'hC && (m_best < 0 || m_id[i] < m_id[m_best])) m_best = i;
                    if (m_best >= 0) begin m_win = m_best; m_next = 1; end
                end
                1: begin
                    s_mb = m_win; s_id = m_id[m_win]; s_len = m_len[m_win];
                    s_dat = m_dat[m_win]; m_cap = '0; m_next = 2;
                end
                2: begin
                    if (id_field_start) m_cap = timer_now;
                    if (tx_done_ok) m_next = 3;
                    else if (tx_lost) m_next = 0;
                end
                default: begin m_set[m_win] = 1'b1; m_next = 0; end
            endcase
            if (cpu_wr_en) begin
                case (cpu_wr_sel)
                    2'd0: begin m_code[cpu_wr_idx] = cpu_wr_data[11:8]; m_len[cpu_wr_idx] = cpu_wr_data[3:0]; end
                    2'd1: m_id[cpu_wr_idx] = cpu_wr_data[10:0];
                    2'd2: m_dat[cpu_wr_idx][31:0] = cpu_wr_data;
                    default: m_dat[cpu_wr_idx][63:32] = cpu_wr_data;
                endcase
            end
            if (m_phase == 3) begin m_code[m_win] = 4'h8; m_ts[m_win] = m_cap; end
            m_flag = (m_flag & ~cpu_flag_clr) | m_set;
            m_phase = m_next;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 smb_valid", 64'(smb_valid), 64'(m_phase == 2));
            if (m_phase == 2) begin
                chk("R2 smb_mb", 64'(smb_mb), 64'(s_mb));
                chk("R3 smb_id", 64'(smb_id), 64'(s_id));
                chk("R3 smb_len", 64'(smb_len), 64'(s_len));
                chk("R3 smb_data", smb_data, s_dat);
                chk("R4 smb_nbytes", 64'(smb_nbytes), 64'((s_len > 4'd8) ? 4'd8 : s_len));
            end
            chk("R8 rd_code", 64'(cpu_rd_code), 64'(m_code[cpu_rd_idx]));
            chk("R5 rd_stamp", 64'(cpu_rd_stamp), 64'(m_ts[cpu_rd_idx]));
            chk("R9 irq_flags", 64'(irq_flags), 64'(m_flag));
        end
    end

    always begin
        @(posedge clk); #1;
        timer_now = timer_now + 16'd3;
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input int idx, input int sel, input logic [31:0] d);
        cpu_wr_en = 1'b1; cpu_wr_idx = 2'(idx); cpu_wr_sel = 2'(sel); cpu_wr_data = d;
        step();
        cpu_wr_en = 1'b0;
    endtask

    task automatic setup_mb(input int idx, input logic [10:0] id, input logic [63:0] d,
                            input logic [3:0] code, input logic [3:0] len);
        wr(idx, 1, {21'd0, id});
        wr(idx, 2, d[31:0]);
        wr(idx, 3, d[63:32]);
        wr(idx, 0, {20'd0, code, 4'd0, len});
    endtask

    task automatic strobe(input bit use_gap);
        if (use_gap) ifs_gap = 1'b1; else bus_free = 1'b1;
        step();
        ifs_gap = 1'b0; bus_free = 1'b0;
    endtask

    task automatic send(input bit ok, input int id_delay);
        step(id_delay);
        id_field_start = 1'b1; step(); id_field_start = 1'b0;
        step(3);
        if (ok) tx_done_ok = 1'b1; else tx_lost = 1'b1;
        step();
        tx_done_ok = 1'b0; tx_lost = 1'b0;
    endtask

    task automatic at_neg;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        at_neg();
        chk("R10 reset smb_valid", 64'(smb_valid), 64'd0);
        chk("R10 reset flags", 64'(irq_flags), 64'd0);
        chk("R10 reset code", 64'(cpu_rd_code), 64'd0);
        chk("R10 reset stamp", 64'(cpu_rd_stamp), 64'd0);
        step();

        // R1: strobe with nothing pending has no effect
        strobe(0);
        step(3); at_neg();
        chk("R1 no pending no start", 64'(smb_valid), 64'd0);
        step();

        setup_mb(0, 11'h123, 64'h5566778811223344, 4'hC, 4'd4);
        setup_mb(1, 11'h055, 64'hAABBCCDD01020304, 4'hC, 4'd12);
        setup_mb(2, 11'h055, 64'h0F0E0D0C0B0A0908, 4'hC, 4'd2);
        setup_mb(3, 11'h001, 64'h1, 4'h8, 4'd8);   // R8: idle code not pending

        strobe(1);
        step(); at_neg();
        chk("R1 valid two cycles after strobe", 64'(smb_valid), 64'd1);
        chk("R2 tie goes to lower index", 64'(smb_mb), 64'd1);
        chk("R4 length above eight clipped", 64'(smb_nbytes), 64'd8);
        step();
        strobe(0);                                  // R1: ignored while busy
        send(1, 1);
        step(2);
        cpu_rd_idx = 2'd1; at_neg();
        chk("R6 code after success", 64'(cpu_rd_code), 64'h8);
        chk("R6 flag after success", 64'(irq_flags[1]), 64'd1);
        step();

        strobe(0);
        step(2);
        send(0, 0);
        cpu_rd_idx = 2'd2; at_neg();
        chk("R7 code stays pending", 64'(cpu_rd_code), 64'hC);
        step();
        strobe(1);
        step(); at_neg();
        chk("R7 rearbitrated", 64'(smb_mb), 64'd2);
        step();
        send(1, 2);
        step(3);

        cpu_flag_clr = 4'b0010; step(); cpu_flag_clr = '0; at_neg();
        chk("R9 flag cleared", 64'(irq_flags[1]), 64'd0);
        step();

        // Sweep rounds with mixed identifiers, losses and clears
        for (int r = 0; r < 12; r++) begin
            for (int i = 0; i < NMB; i++)
                setup_mb(i, 11'((r * 397 + i * 913 + ((i == 3) ? 0 : r * 11)) % 2048),
                         {32'(r * 7 + i), 32'(r ^ i)}, ((r + i) % 5 == 4) ? 4'h8 : 4'hC,
                         4'((r * 3 + i) % 16));
            for (int k = 0; k < 6; k++) begin
                cpu_rd_idx = 2'(k % NMB);
                strobe(k % 2);
                step(2);
                send(((r + k) % 4) != 1, k % 3);
                cpu_flag_clr = 4'(r + k);
                step();
                cpu_flag_clr = '0;
                step(2);
            end
        end

        step(4);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule